// File: doc/BRIEF.md
# I2C Master Command-Bit Sequencer

This block is a bus master for a two-wire serial bus. Software drives it through a small register port. It sets one-shot command bits to request bus events: a Start, a Repeated Start, a Stop, a one-byte receive, or an acknowledge bit. A byte written to the data register is shifted out MSB first. The slave's acknowledge is sampled on a ninth clock pulse and recorded. Each command bit reads 1 while its event runs, and hardware clears it when the event ends. A one-cycle interrupt pulse marks the end of every operation.

The bus lines are open-drain. The block outputs a pull-low enable for SCL and one for SDA, and it reads the SDA level back. Each SCL phase (high or low) lasts a programmable number of system clocks. Commands are not queued. A control or data write that arrives while an operation runs is discarded and sets a sticky refused-write flag. The register port takes a write in a single cycle and has no back-pressure: the refused-write flag is the only sign that a write was dropped. Nothing at the block's edge is a valid/ready stream.

Register map (2-bit address):
- Address 0 is control. Bit 0 is Start, bit 1 is Repeated Start, bit 2 is Stop, bit 3 is receive byte, bit 4 is acknowledge sequence, and bit 5 is the acknowledge value.
- Address 1 is the data register: a write transmits a byte, and a read returns the received byte.
- Address 2 is status. Bit 0 is ack-missing, bit 1 is busy, and bit 2 is the refused-write flag. Any write to address 2 clears the refused-write flag.
- Address 3 is the phase divider.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, every control bit, the acknowledge value, every status bit and the received byte read 0. The divider reads DIV_INIT (4). Both line enables are 0 (released) and irq is 0.
- R2: Control bit 0 makes SDA fall while SCL is high, then pulls SCL low. SCL and SDA are left driven low.
- R3: Control bit 1 releases SDA while SCL is low, then releases SCL, then pulls SDA low while SCL is high, then pulls SCL low.
- R4: Control bit 2 pulls SDA low while SCL is low, then releases SCL, then releases SDA while SCL is high. Both lines are left released.
- R5: A write to address 1 while idle sends the 8 bits MSB first on 8 SCL pulses. SDA is then released for a ninth pulse. Status bit 0 takes the SDA level sampled on that pulse: 1 means no acknowledge.
- R6: Control bit 3 releases SDA and samples it at the end of each of 8 SCL high phases. The byte is assembled MSB first and read at address 1.
- R7: Control bit 4 drives the acknowledge value (control bit 5: 0 = ACK, 1 = NACK) on SDA for one SCL pulse.
- R8: Every phase lasts divider+1 clocks. irq rises N×(divider+1) clocks after the accepting write edge, where N is 2 for Start, 4 for Repeated Start, 3 for Stop, 19 for transmit, 17 for receive and 3 for acknowledge.
- R9: irq is high for exactly one cycle at the end of each operation.
- R10: While busy (status bit 1), a write to address 0 or 1 changes nothing: no command, no acknowledge value, no data. It sets status bit 2 instead. A write to address 2 clears that bit.
- R11: When one control write sets several command bits, only the lowest-numbered one runs.
- R12: SDA changes only while SCL is low, except inside Start, Repeated Start and Stop.
- R13: A command bit reads 1 from the accepting write until its operation ends, then reads 0. At most one command bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sensed SDA level |
| irq | output | 1 | One-cycle completion pulse |

## Verification
An operation can end in the same cycle that software writes the next command. The end of the operation drops busy and raises irq, while the write is checked for refusal. The bench provokes this by timing a Stop write into the final clock of a transmit. It then checks that irq fired, that the refused-write flag is set and that no Stop ran. A follow-up command is then shown to be accepted normally. A multi-bit control write checks the priority rule on the same edge that launches the operation.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_N  = 5;
  localparam int STEP_W = 5;
  localparam int ACKV_BIT = 5;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;

  // command encodings equal their control bit index; TX has no bit
  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_STOP   = 3'd2,
    OP_RX     = 3'd3,
    OP_ACK    = 3'd4,
    OP_TX     = 3'd5
  } op_e;

  typedef struct packed {
    logic scl_rel;
    logic sda_rel;
  } lines_t;

  function automatic logic [STEP_W-1:0] last_step(op_e op);
    case (op)
      OP_START:  return STEP_W'(1);
      OP_RSTART: return STEP_W'(3);
      OP_STOP:   return STEP_W'(2);
      OP_RX:     return STEP_W'(2*BYTE_W);
      OP_ACK:    return STEP_W'(2);
      default:   return STEP_W'(2*BYTE_W+2);
    endcase
  endfunction

  function automatic logic is_bus_cond(op_e op);
    return (op == OP_START) || (op == OP_RSTART) || (op == OP_STOP);
  endfunction
endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             phase_end
);
  logic [DIV_W-1:0] cnt;

  assign phase_end = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= div;
    end else if (run) begin
      if (cnt == '0) cnt <= div;
      else           cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/i2c_cmd_regs.sv
module i2c_cmd_regs
  import i2c_seq_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DIV_INIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  output logic              launch,
  output op_e               launch_op,
  output logic [BYTE_W-1:0] tx_data,
  output logic              ack_val,
  output logic [DIV_W-1:0]  div,
  output logic              wcol
);
  logic             ctrl_wr, data_wr, stat_wr, div_wr, refuse;
  logic [CMD_N-1:0] cmd_req;
  op_e              pick;

  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign data_wr = wr_en && (addr == A_DATA);
  assign stat_wr = wr_en && (addr == A_STAT);
  assign div_wr  = wr_en && (addr == A_DIV);
  assign cmd_req = wdata[CMD_N-1:0];

  // lowest-numbered request wins
  always_comb begin
    pick = OP_ACK;
    for (int i = CMD_N-1; i >= 0; i--) begin
      if (cmd_req[i]) pick = op_e'(3'(i));
    end
  end

  assign refuse    = busy && (ctrl_wr || data_wr);
  assign launch    = !busy && ((ctrl_wr && (|cmd_req)) || data_wr);
  assign launch_op = data_wr ? OP_TX : pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data <= '0;
      ack_val <= 1'b0;
      div     <= DIV_W'(DIV_INIT);
      wcol    <= 1'b0;
    end else begin
      if (ctrl_wr && !busy) ack_val <= wdata[ACKV_BIT];
      if (data_wr && !busy) tx_data <= wdata[BYTE_W-1:0];
      if (div_wr)           div     <= wdata[DIV_W-1:0];
      if (refuse)           wcol    <= 1'b1;
      else if (stat_wr)     wcol    <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  op_e               launch_op,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              ack_val,
  input  logic              sda_in,
  input  logic              phase_end,
  output logic              busy,
  output op_e               op,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_data,
  output logic              ack_miss,
  output logic              irq,
  output logic              cond_active
);
  logic [STEP_W-1:0] step;
  logic [3:0]        bit_idx;
  lines_t            cur;
  logic              hold_scl_oe, hold_sda_oe;
  logic              fin, smp_ack, smp_rx;

  assign bit_idx = step[STEP_W-1:1];

  // line levels for the current step (rel = 1 means released)
  always_comb begin
    cur = '{scl_rel: 1'b0, sda_rel: 1'b1};
    case (op)
      OP_START: begin
        cur.scl_rel = (step == STEP_W'(0));
        cur.sda_rel = 1'b0;
      end
      OP_RSTART: begin
        cur.scl_rel = (step == STEP_W'(1)) || (step == STEP_W'(2));
        cur.sda_rel = (step == STEP_W'(0)) || (step == STEP_W'(1));
      end
      OP_STOP: begin
        cur.scl_rel = (step != STEP_W'(0));
        cur.sda_rel = (step == STEP_W'(2));
      end
      OP_RX: begin
        cur.scl_rel = step[0];
        cur.sda_rel = 1'b1;
      end
      OP_ACK: begin
        cur.scl_rel = step[0];
        cur.sda_rel = ack_val;
      end
      default: begin
        cur.scl_rel = step[0];
        cur.sda_rel = (bit_idx < 4'd8) ? tx_data[3'(4'd7 - bit_idx)] : 1'b1;
      end
    endcase
  end

  assign fin     = phase_end && (step == last_step(op));
  assign smp_ack = phase_end && step[0] && (op == OP_TX) && (bit_idx == 4'd8);
  assign smp_rx  = phase_end && step[0] && (op == OP_RX) && (bit_idx < 4'd8);

  assign scl_oe      = busy ? !cur.scl_rel : hold_scl_oe;
  assign sda_oe      = busy ? !cur.sda_rel : hold_sda_oe;
  assign cond_active = busy && is_bus_cond(op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      op          <= OP_START;
      step        <= '0;
      hold_scl_oe <= 1'b0;
      hold_sda_oe <= 1'b0;
      rx_data     <= '0;
      ack_miss    <= 1'b0;
      irq         <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (launch) begin
        busy <= 1'b1;
        op   <= launch_op;
        step <= '0;
      end else if (fin) begin
        busy        <= 1'b0;
        irq         <= 1'b1;
        hold_scl_oe <= !cur.scl_rel;
        hold_sda_oe <= !cur.sda_rel;
      end else if (phase_end) begin
        step <= step + 1'b1;
      end
      if (smp_ack) ack_miss <= sda_in;
      if (smp_rx)  rx_data  <= {rx_data[BYTE_W-2:0], sda_in};
    end
  end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_seq_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DIV_INIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in,
  output logic       irq
);
  logic              launch, busy, phase_end, ack_val, wcol, ack_miss, cond_active;
  op_e               launch_op, op;
  logic [BYTE_W-1:0] tx_data, rx_data;
  logic [DIV_W-1:0]  div;
  logic [CMD_N-1:0]  cmd_bits;

  i2c_cmd_regs #(.DIV_W(DIV_W), .DIV_INIT(DIV_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .launch(launch), .launch_op(launch_op), .tx_data(tx_data),
    .ack_val(ack_val), .div(div), .wcol(wcol)
  );

  i2c_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(launch), .run(busy), .div(div),
    .phase_end(phase_end)
  );

  i2c_bit_engine u_engine (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_op(launch_op),
    .tx_data(tx_data), .ack_val(ack_val), .sda_in(sda_in), .phase_end(phase_end),
    .busy(busy), .op(op), .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data),
    .ack_miss(ack_miss), .irq(irq), .cond_active(cond_active)
  );

  // command bit i reads 1 while operation i runs
  for (genvar i = 0; i < CMD_N; i++) begin : g_cmd
    assign cmd_bits[i] = busy && (op == op_e'(3'(i)));
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {2'b00, ack_val, cmd_bits};
      A_DATA:  reg_rdata = rx_data;
      A_STAT:  reg_rdata = {5'b00000, wcol, busy, ack_miss};
      default: reg_rdata = 8'(div);
    endcase
  end
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk
  import i2c_seq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic             busy,
  input logic             irq,
  input logic             wcol,
  input logic [CMD_N-1:0] cmd_bits,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             cond_active
);
  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  p_refuse_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && busy && (reg_addr == A_CTRL || reg_addr == A_DATA)) |=> wcol);

  p_cmd_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_bits));

  p_sda_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && !cond_active) |-> (sda_oe == $past(sda_oe)));

  p_cmd_cleared_r13: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cmd_bits == '0));

  p_cmd_only_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_bits) |-> busy);
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .busy(busy),
  .irq(irq), .wcol(wcol), .cmd_bits(cmd_bits), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .cond_active(cond_active)
);

// File: tb/test_i2c_cmd_master.sv
`timescale 1ns/1ps
module test_i2c_cmd_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe, irq;
  logic       scl_line, sda_line, slv_pull;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  i2c_cmd_master i_i2c_cmd_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda_line), .irq(irq)
  );

  // bus model and slave
  int         slv_mode = 0;   // 0 idle, 1 ack a transmit, 2 send a byte
  logic       slv_ack = 1'b0;
  logic [7:0] slv_pat = 8'd0;
  int         fall_base = 0;
  int         rise_tot = 0, fall_tot = 0, start_tot = 0, stop_tot = 0;
  logic [15:0] bits = '0;
  logic       p_scl = 1'b1, p_sda = 1'b1;
  int         rel_fall;

  assign rel_fall = fall_tot - fall_base;
  assign slv_pull = (slv_mode == 1 && slv_ack && rel_fall == 8) ||
                    (slv_mode == 2 && rel_fall >= 0 && rel_fall < 8 && !slv_pat[3'(7 - rel_fall)]);
  assign scl_line = !scl_oe;
  assign sda_line = !sda_oe && !slv_pull;

  always @(negedge clk) begin
    if (p_scl && scl_line && p_sda && !sda_line) start_tot <= start_tot + 1;
    if (p_scl && scl_line && !p_sda && sda_line) stop_tot <= stop_tot + 1;
    if (!p_scl && scl_line) begin
      rise_tot <= rise_tot + 1;
      bits <= {bits[14:0], sda_line};
    end
    if (p_scl && !scl_line) fall_tot <= fall_tot + 1;
    p_scl <= scl_line;
    p_sda <= sda_line;
  end

  initial begin
    #(200000 * 5);
    $display("watchdog expired FAIL");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_op(output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!irq && n < 4000);
    if (n >= 4000) check("R9 irq watchdog", 0, 1);
  endtask

  int sr, ss, st;
  task automatic snap();
    sr = rise_tot; ss = start_tot; st = stop_tot; fall_base = fall_tot;
  endtask

  // {kind(0 tx,1 rx,2 ack), data, flag, divider}
  localparam int NV = 8;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 8'hA5, 1'b1, 8'd1},
    {2'd0, 8'h3C, 1'b0, 8'd0},
    {2'd1, 8'h96, 1'b0, 8'd2},
    {2'd2, 8'h00, 1'b0, 8'd1},
    {2'd0, 8'hFF, 1'b1, 8'd3},
    {2'd1, 8'h01, 1'b0, 8'd0},
    {2'd2, 8'h00, 1'b1, 8'd0},
    {2'd0, 8'h00, 1'b0, 8'd2}
  };

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 8'h00);
    rd(2'd1, v); check("R1 rx", v, 8'h00);
    rd(2'd2, v); check("R1 status", v, 8'h00);
    rd(2'd3, v); check("R1 divider", v, 8'd4);
    check("R1 scl_oe", scl_oe, 0);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 irq", irq, 0);

    // R2 start with divider 2
    wr(2'd3, 8'd2);
    snap();
    wr(2'd0, 8'h01);
    rd(2'd0, v); check("R13 start bit set", v, 8'h01);
    wait_op(n);
    check("R8 start cycles", n, 6);
    check("R2 start seen", start_tot - ss, 1);
    rd(2'd0, v); check("R13 start bit cleared", v, 8'h00);
    check("R2 scl low", scl_oe, 1);
    check("R2 sda low", sda_oe, 1);
    @(posedge clk); #1;
    check("R9 irq one cycle", irq, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0] kind; logic [7:0] dat; logic flg; logic [7:0] dv;
      {kind, dat, flg, dv} = VEC[i];
      wr(2'd3, dv);
      slv_mode = (kind == 2'd0) ? 1 : (kind == 2'd1) ? 2 : 0;
      slv_ack = flg; slv_pat = dat;
      snap();
      if (kind == 2'd0) begin
        wr(2'd1, dat);
        wait_op(n);
        check("R8 tx cycles", n, 19 * (dv + 1));
        check("R5 tx pulses", rise_tot - sr, 9);
        check("R5 tx bits msb first", bits[8:1], dat);
        rd(2'd2, v); check("R5 ack status", v[0], !flg);
        check("R12 no cond in tx", (start_tot - ss) + (stop_tot - st), 0);
      end else if (kind == 2'd1) begin
        wr(2'd0, 8'h08);
        wait_op(n);
        check("R8 rx cycles", n, 17 * (dv + 1));
        rd(2'd1, v); check("R6 rx byte", v, dat);
        check("R6 rx pulses", rise_tot - sr, 8);
        check("R12 no cond in rx", (start_tot - ss) + (stop_tot - st), 0);
      end else begin
        wr(2'd0, {2'b00, flg, 5'b10000});
        wait_op(n);
        check("R8 ack cycles", n, 3 * (dv + 1));
        check("R7 ack pulses", rise_tot - sr, 1);
        check("R7 ack level", bits[0], flg);
      end
      slv_mode = 0;
    end

    // R10 refusal while busy (ack value is 1 from the last ACK vector)
    wr(2'd3, 8'd1);
    slv_mode = 1; slv_ack = 1'b1;
    snap();
    wr(2'd1, 8'h5A);
    repeat (4) @(posedge clk);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h05);
    rd(2'd0, v); check("R10 ctrl unchanged while busy", v, 8'h20);
    rd(2'd2, v); check("R10 busy and flag", v[2:1], 2'b11);
    wait_op(n);
    check("R10 first byte kept", bits[8:1], 8'h5A);
    rd(2'd0, v); check("R10 no command ran", v, 8'h20);
    wr(2'd2, 8'h00);
    rd(2'd2, v); check("R10 flag cleared", v[2], 0);

    // write in the final cycle of a transmit: refused
    snap();
    wr(2'd1, 8'hC3);
    repeat (37) @(posedge clk);
    wr(2'd0, 8'h04);
    #1;
    check("R9 irq on final edge", irq, 1);
    rd(2'd2, v); check("R10 final-cycle write refused", v[2:1], 2'b10);
    rd(2'd0, v); check("R10 stop not started", v[4:0], 5'b00000);
    check("R5 tx bits", bits[8:1], 8'hC3);
    wr(2'd2, 8'h00);
    slv_mode = 0;

    // R11 priority: rstart wins over stop, rx, ack
    wr(2'd3, 8'd0);
    snap();
    wr(2'd0, 8'h1E);
    rd(2'd0, v); check("R11 only rstart bit", v, 8'h02);
    wait_op(n);
    check("R8 rstart cycles", n, 4);
    check("R3 rstart cond", start_tot - ss, 1);
    check("R3 rstart one pulse", rise_tot - sr, 1);
    check("R3 lines low after", {scl_oe, sda_oe}, 2'b11);

    // R11 stop wins over rx
    snap();
    wr(2'd0, 8'h0C);
    rd(2'd0, v); check("R11 only stop bit", v, 8'h04);
    wait_op(n);
    check("R8 stop cycles", n, 3);
    check("R4 stop cond", stop_tot - st, 1);
    check("R4 lines released", {scl_oe, sda_oe}, 2'b00);
    rd(2'd0, v); check("R13 stop bit cleared", v, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule